// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block holds the running time of day and the calendar (seconds, minutes, hours, weekday, day of month, month and two-digit year of the 2000 to 2099 century). Everything runs on the fast system clock. A once-per-second tick does not clock any register. It only enables a single-cycle rollover that carries through every field. The tick comes from one of two sources. The first is a slow reference that is synchronised and then divided by `REF_DIV`. The second is an external 1 Hz pulse, which replaces the divided reference when `pulse_sel` is high.

Software reaches the counters through a byte-wide register port with a 6-bit address. The control register sets three things: the number format (BCD or plain binary), the hour style (24-hour, or 12-hour with a PM flag), and a hold bit that freezes counting while a new time is loaded. Values are converted on the way out, and written values are decoded using the format selected at the moment of the write. Storage is always binary and 24-hour. A one-cycle `upd_done` strobe marks each completed advance, so software knows when it can safely access the counters.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00 and control 0x02 (BCD, 24-hour). Addresses that are not mapped read 0x00.
- R2: With `pulse_sel` high, each rising edge of `pulse_1hz` advances the time by one second. The advance and the `upd_done` strobe appear no more than 6 clock cycles after the edge.
- R3: With `pulse_sel` low, the time advances once for every `REF_DIV` rising edges of `ref_clk`, and edges on `pulse_1hz` change nothing.
- R4: Register map: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day 0x07, month 0x08, year 0x09, control 0x0B. In the control register, bit 2 = 1 selects binary and bit 2 = 0 selects packed BCD (tens digit in bits 7:4). Changing bit 2 does not alter the stored time; only the read encoding changes.
- R5: When control bit 1 is 0, the hours read back as 1 to 12 with bit 7 set for PM. Hour 0 reads as 12 AM, hour 12 as 12 PM and hour 13 as 1 PM.
- R6: In 12-hour mode a written hour is decoded the reverse way: 12 AM stores 0, 12 PM stores 12, and n PM stores n+12.
- R7: 23:59:59 advances to 00:00:00, moves the date forward one day and steps the weekday, with weekday 7 wrapping to 1. This holds in both binary and BCD.
- R8: April, June, September and November end after day 30. The other months, except February, end after day 31.
- R9: February has 29 days when the year is divisible by four and 28 otherwise. 31 December of year 99 rolls over to 1 January of year 00.
- R10: While control bit 7 (hold) is set, the counters do not advance. When hold is cleared, one advance is made if at least one tick arrived during the hold.
- R11: Control bit 0 (daylight-saving enable) is stored but has no effect on counting.
- R12: `upd_done` is high for one cycle per advance. Without a write, the seconds only change in a cycle that raises `upd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select, active high |
| bus_wr | input | 1 | 1 = write at this clock edge, 0 = read |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ref_clk | input | 1 | Slow reference, asynchronous to `clk` |
| pulse_1hz | input | 1 | External once-per-second pulse, asynchronous |
| pulse_sel | input | 1 | 1 = tick from `pulse_1hz`, 0 = tick from divided `ref_clk` |
| upd_done | output | 1 | One-cycle strobe after each advance |

## Verification
The range assertions on the stored fields assume software only writes legal values: minutes and seconds below 60, hours that decode to 0 to 23, day 1 to 31, month 1 to 12, and digits coded in the format currently selected. The single-cycle strobe assertion assumes `pulse_sel` stays steady while ticks arrive, so the two sources cannot deliver edges on adjacent cycles. The stimulus writes only legal encodings that match the control register at the time of each write. It changes `pulse_sel` only while both tick inputs are idle, and it spaces its pulses and reference edges several cycles apart, so every edge passes through the synchroniser.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int SEC_W = 6;
   localparam int MIN_W = 6;
   localparam int HR_W  = 5;
   localparam int DOW_W = 3;
   localparam int DOM_W = 5;
   localparam int MON_W = 4;
   localparam int YR_W  = 7;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 8;

   localparam logic [ADDR_W-1:0] A_SEC  = 6'h00;
   localparam logic [ADDR_W-1:0] A_MIN  = 6'h02;
   localparam logic [ADDR_W-1:0] A_HR   = 6'h04;
   localparam logic [ADDR_W-1:0] A_DOW  = 6'h06;
   localparam logic [ADDR_W-1:0] A_DOM  = 6'h07;
   localparam logic [ADDR_W-1:0] A_MON  = 6'h08;
   localparam logic [ADDR_W-1:0] A_YR   = 6'h09;
   localparam logic [ADDR_W-1:0] A_CTL  = 6'h0B;

   localparam int CTL_HOLD = 7;
   localparam int CTL_BIN  = 2;
   localparam int CTL_H24  = 1;
   localparam int CTL_DST  = 0;
   localparam logic [DATA_W-1:0] CTL_MASK  = 8'h87;
   localparam logic [DATA_W-1:0] CTL_RESET = 8'h02;

   typedef struct packed {
      logic [YR_W-1:0]  yr;
      logic [MON_W-1:0] mon;
      logic [DOM_W-1:0] mday;
      logic [DOW_W-1:0] wday;
      logic [HR_W-1:0]  hrs;
      logic [MIN_W-1:0] mins;
      logic [SEC_W-1:0] sec;
   } rtc_time_t;

   // binary value (0..99) to register byte
   function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
      logic [6:0] tens;
      logic [6:0] ones;
      tens = v / 7'd10;
      ones = v % 7'd10;
      return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
   endfunction

   // register byte to binary value
   function automatic logic [6:0] dec_val(input logic [7:0] d, input logic bin);
      logic [6:0] tens;
      tens = {3'b000, d[7:4]};
      return bin ? d[6:0] : 7'(tens * 7'd10 + {3'b000, d[3:0]});
   endfunction

   function automatic logic [7:0] enc_hour(input logic [HR_W-1:0] h, input logic bin,
                                           input logic h24);
      logic [6:0] h12;
      logic       pm;
      logic [7:0] e;
      if (h24) return enc_val(7'(h), bin);
      pm = (h >= 5'd12);
      if (h == 5'd0)       h12 = 7'd12;
      else if (h > 5'd12)  h12 = 7'(h - 5'd12);
      else                 h12 = 7'(h);
      e = enc_val(h12, bin);
      return {pm, e[6:0]};
   endfunction

   function automatic logic [HR_W-1:0] dec_hour(input logic [7:0] d, input logic bin,
                                                input logic h24);
      logic [6:0] v;
      if (h24) begin
         v = dec_val(d, bin);
         return v[HR_W-1:0];
      end
      v = dec_val({1'b0, d[6:0]}, bin);
      if (v == 7'd12) return d[7] ? 5'd12 : 5'd0;
      return d[7] ? 5'(v + 7'd12) : v[HR_W-1:0];
   endfunction

   function automatic logic [DOM_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                  input logic [YR_W-1:0] y);
      case (m)
         4'd2:                      return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
         default:                   return 5'd31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
   parameter int STAGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 3) begin : g_bad_stages
      $error("rtc_edge_sync: STAGES must be at least 3");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign rise = chain[STAGES-2] & ~chain[STAGES-1];

   assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/rtc_tick_src.sv
module rtc_tick_src #(
   parameter int REF_DIV = 32768,
   parameter int SYNC_FF = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_clk,
   input  logic pulse_1hz,
   input  logic pulse_sel,
   output logic sec_tick
);
   localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

   if (REF_DIV < 1) begin : g_bad_div
      $error("rtc_tick_src: REF_DIV must be positive");
   end

   logic ref_rise;
   logic pls_rise;
   logic div_tick;

   rtc_edge_sync #(.STAGES(SYNC_FF)) u_ref_sync (
      .clk(clk), .rst_n(rst_n), .din(ref_clk), .rise(ref_rise));

   rtc_edge_sync #(.STAGES(SYNC_FF)) u_pls_sync (
      .clk(clk), .rst_n(rst_n), .din(pulse_1hz), .rise(pls_rise));

   if (REF_DIV == 1) begin : g_direct
      assign div_tick = ref_rise;
   end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt <= '0;
         else if (ref_rise) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
      end
      assign div_tick = ref_rise && (cnt == LAST);

      assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
         32'(cnt) < REF_DIV);
   end

   assign sec_tick = pulse_sel ? pls_rise : div_tick;
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
   import rtc_pkg::*;
#(
   parameter int YEAR_SPAN = 100
) (
   input  rtc_time_t cur,
   output rtc_time_t nxt
);
   if (YEAR_SPAN < 4 || YEAR_SPAN > (1 << YR_W)) begin : g_bad_span
      $error("rtc_cal_step: YEAR_SPAN out of range");
   end

   localparam logic [YR_W-1:0] YR_LAST = YR_W'(YEAR_SPAN - 1);

   logic [DOM_W-1:0] dim;

   always_comb begin
      nxt = cur;
      dim = month_len(cur.mon, cur.yr);
      if (cur.sec != SEC_W'(59)) begin
         nxt.sec = cur.sec + SEC_W'(1);
      end else begin
         nxt.sec = '0;
         if (cur.mins != MIN_W'(59)) begin
            nxt.mins = cur.mins + MIN_W'(1);
         end else begin
            nxt.mins = '0;
            if (cur.hrs != HR_W'(23)) begin
               nxt.hrs = cur.hrs + HR_W'(1);
            end else begin
               nxt.hrs  = '0;
               nxt.wday = (cur.wday == DOW_W'(7)) ? DOW_W'(1) : cur.wday + DOW_W'(1);
               if (cur.mday != dim) begin
                  nxt.mday = cur.mday + DOM_W'(1);
               end else begin
                  nxt.mday = DOM_W'(1);
                  if (cur.mon != MON_W'(12)) begin
                     nxt.mon = cur.mon + MON_W'(1);
                  end else begin
                     nxt.mon = MON_W'(1);
                     nxt.yr  = (cur.yr == YR_LAST) ? '0 : cur.yr + YR_W'(1);
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_pkg::*;
#(
   parameter int REF_DIV = 32768,
   parameter int SYNC_FF = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ref_clk,
   input  logic              pulse_1hz,
   input  logic              pulse_sel,
   output logic              upd_done
);
   rtc_time_t         cur;
   rtc_time_t         nxt;
   logic [DATA_W-1:0] ctl_q;
   logic              pending;
   logic              sec_tick;
   logic              wr_any;
   logic              advance;
   logic              hold_q;
   logic              fmt_bin;
   logic              fmt_h24;
   logic [6:0]        wr_val;
   logic [HR_W-1:0]   wr_hr;

   rtc_tick_src #(.REF_DIV(REF_DIV), .SYNC_FF(SYNC_FF)) u_tick (
      .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .pulse_1hz(pulse_1hz),
      .pulse_sel(pulse_sel), .sec_tick(sec_tick));

   rtc_cal_step #(.YEAR_SPAN(100)) u_step (.cur(cur), .nxt(nxt));

   assign hold_q  = ctl_q[CTL_HOLD];
   assign fmt_bin = ctl_q[CTL_BIN];
   assign fmt_h24 = ctl_q[CTL_H24];
   assign wr_any  = bus_sel & bus_wr;
   assign advance = (sec_tick | pending) & ~hold_q & ~wr_any;
   assign wr_val  = dec_val(bus_wdata, fmt_bin);
   assign wr_hr   = dec_hour(bus_wdata, fmt_bin, fmt_h24);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= '{yr: '0, mon: MON_W'(1), mday: DOM_W'(1), wday: DOW_W'(1),
                       hrs: '0, mins: '0, sec: '0};
         ctl_q    <= CTL_RESET;
         pending  <= 1'b0;
         upd_done <= 1'b0;
      end else begin
         pending  <= (pending | sec_tick) & ~advance;
         upd_done <= advance;
         if (advance) cur <= nxt;
         if (wr_any) begin
            case (bus_addr)
               A_SEC:   cur.sec  <= wr_val[SEC_W-1:0];
               A_MIN:   cur.mins <= wr_val[MIN_W-1:0];
               A_HR:    cur.hrs  <= wr_hr;
               A_DOW:   cur.wday <= wr_val[DOW_W-1:0];
               A_DOM:   cur.mday <= wr_val[DOM_W-1:0];
               A_MON:   cur.mon  <= wr_val[MON_W-1:0];
               A_YR:    cur.yr   <= wr_val[YR_W-1:0];
               A_CTL:   ctl_q    <= bus_wdata & CTL_MASK;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (bus_addr)
            A_SEC:   bus_rdata = enc_val(7'(cur.sec), fmt_bin);
            A_MIN:   bus_rdata = enc_val(7'(cur.mins), fmt_bin);
            A_HR:    bus_rdata = enc_hour(cur.hrs, fmt_bin, fmt_h24);
            A_DOW:   bus_rdata = enc_val(7'(cur.wday), fmt_bin);
            A_DOM:   bus_rdata = enc_val(7'(cur.mday), fmt_bin);
            A_MON:   bus_rdata = enc_val(7'(cur.mon), fmt_bin);
            A_YR:    bus_rdata = enc_val(cur.yr, fmt_bin);
            A_CTL:   bus_rdata = ctl_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assert_time_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cur.sec < SEC_W'(60) && cur.mins < MIN_W'(60) && cur.hrs < HR_W'(24));

   assert_date_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cur.mday != '0 && cur.mon != '0 && cur.mon <= MON_W'(12) && cur.wday != '0);

   assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !wr_any) |=> $stable(cur));

   assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |=> !upd_done);

   assert_sec_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.sec != $past(cur.sec) && !$past(wr_any)) |-> upd_done);
endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 15;
   localparam int TB_DIV = 4;

   // ctl, sec, min, hr, dow, dom, mon, yr | exp sec, min, hr, dow, dom, mon, yr
   localparam logic [7:0] VEC [0:NV-1][0:14] = '{
      '{8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00},
      '{8'h06, 8'h3B, 8'h3B, 8'h17, 8'h03, 8'h0F, 8'h06, 8'h07, 8'h00, 8'h00, 8'h00, 8'h04, 8'h10, 8'h06, 8'h07},
      '{8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h08, 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h08},
      '{8'h02, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h07, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h07},
      '{8'h02, 8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h08, 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h08},
      '{8'h02, 8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23, 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h23},
      '{8'h02, 8'h59, 8'h59, 8'h23, 8'h06, 8'h30, 8'h01, 8'h23, 8'h00, 8'h00, 8'h00, 8'h07, 8'h31, 8'h01, 8'h23},
      '{8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h11, 8'h23, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h12, 8'h23},
      '{8'h00, 8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h03, 8'h20, 8'h00, 8'h00, 8'h92, 8'h01, 8'h10, 8'h03, 8'h20},
      '{8'h00, 8'h59, 8'h59, 8'h91, 8'h01, 8'h10, 8'h03, 8'h20, 8'h00, 8'h00, 8'h12, 8'h02, 8'h11, 8'h03, 8'h20},
      '{8'h04, 8'h3B, 8'h3B, 8'h0C, 8'h01, 8'h05, 8'h05, 8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h05, 8'h05, 8'h05},
      '{8'h04, 8'h3B, 8'h3B, 8'h8C, 8'h01, 8'h05, 8'h05, 8'h05, 8'h00, 8'h00, 8'h81, 8'h01, 8'h05, 8'h05, 8'h05},
      '{8'h02, 8'h08, 8'h12, 8'h13, 8'h03, 8'h14, 8'h07, 8'h30, 8'h09, 8'h12, 8'h13, 8'h03, 8'h14, 8'h07, 8'h30},
      '{8'h00, 8'h30, 8'h45, 8'h81, 8'h03, 8'h14, 8'h07, 8'h30, 8'h31, 8'h45, 8'h81, 8'h03, 8'h14, 8'h07, 8'h30},
      '{8'h02, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h09, 8'h23, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h10, 8'h23}
   };
   localparam logic [5:0] FLD_ADDR [0:6] = '{6'h00, 6'h02, 6'h04, 6'h06, 6'h07, 6'h08, 6'h09};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [5:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ref_clk = 1'b0;
   logic       pulse_1hz = 1'b0;
   logic       pulse_sel = 1'b1;
   logic       upd_done;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] rv;
   int lat;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rtc_calendar_core #(.REF_DIV(TB_DIV), .SYNC_FF(3)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ref_clk(ref_clk), .pulse_1hz(pulse_1hz), .pulse_sel(pulse_sel),
      .upd_done(upd_done));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      pulse_1hz = 1'b1;
      repeat (3) @(negedge clk);
      pulse_1hz = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic ref_edge();
      @(negedge clk);
      ref_clk = 1'b1;
      repeat (3) @(negedge clk);
      ref_clk = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   function automatic string vtag(input int i);
      case (i)
         0, 1:       return "R7 rollover";
         2, 3, 4:    return "R9 february";
         5, 6, 7:    return "R8 month end";
         8, 11:      return "R5 12h read";
         9, 10:      return "R6 12h write";
         12:         return "R4 bcd count";
         13:         return "R5 pm hold";
         default:    return "R8 september";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset values
      rd(6'h00, rv); chk("R1 sec", rv, 8'h00);
      rd(6'h02, rv); chk("R1 min", rv, 8'h00);
      rd(6'h04, rv); chk("R1 hour", rv, 8'h00);
      rd(6'h06, rv); chk("R1 wday", rv, 8'h01);
      rd(6'h07, rv); chk("R1 mday", rv, 8'h01);
      rd(6'h08, rv); chk("R1 month", rv, 8'h01);
      rd(6'h09, rv); chk("R1 year", rv, 8'h00);
      rd(6'h0B, rv); chk("R1 ctl", rv, 8'h02);
      rd(6'h01, rv); chk("R1 unmapped", rv, 8'h00);
      chk("R1 upd_done", {7'b0, upd_done}, 8'h00);

      // vector table
      for (int v = 0; v < NV; v++) begin
         wr(6'h0B, VEC[v][0]);
         for (int f = 0; f < 7; f++) wr(FLD_ADDR[f], VEC[v][f + 1]);
         pulse_tick();
         for (int f = 0; f < 7; f++) begin
            rd(FLD_ADDR[f], rv);
            chk($sformatf("%s vec %0d field %0d", vtag(v), v, f), rv, VEC[v][f + 8]);
         end
      end

      // R2 / R12 latency and strobe width
      wr(6'h0B, 8'h02);
      wr(6'h00, 8'h10);
      @(negedge clk);
      pulse_1hz = 1'b1;
      lat = 0;
      while (!upd_done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      chk("R2 latency within 6", {7'b0, (lat <= 6)}, 8'h01);
      @(negedge clk);
      chk("R12 strobe one cycle", {7'b0, upd_done}, 8'h00);
      pulse_1hz = 1'b0;
      repeat (6) @(negedge clk);
      rd(6'h00, rv); chk("R2 advanced one", rv, 8'h11);

      // R4 format switch keeps stored time
      wr(6'h00, 8'h45);
      wr(6'h0B, 8'h06);
      rd(6'h00, rv); chk("R4 binary read", rv, 8'h2D);
      wr(6'h0B, 8'h02);
      rd(6'h00, rv); chk("R4 bcd read back", rv, 8'h45);

      // R5 12h read of hour 13 and hour 0
      wr(6'h04, 8'h13);
      wr(6'h0B, 8'h00);
      rd(6'h04, rv); chk("R5 13h as 1 PM", rv, 8'h81);
      wr(6'h0B, 8'h02);
      wr(6'h04, 8'h00);
      wr(6'h0B, 8'h00);
      rd(6'h04, rv); chk("R5 0h as 12 AM", rv, 8'h12);

      // R6 12h writes seen in 24h form
      wr(6'h04, 8'h12);
      wr(6'h0B, 8'h02);
      rd(6'h04, rv); chk("R6 12 AM stores 0", rv, 8'h00);
      wr(6'h0B, 8'h00);
      wr(6'h04, 8'h92);
      wr(6'h0B, 8'h02);
      rd(6'h04, rv); chk("R6 12 PM stores 12", rv, 8'h12);
      wr(6'h0B, 8'h00);
      wr(6'h04, 8'h83);
      wr(6'h0B, 8'h02);
      rd(6'h04, rv); chk("R6 3 PM stores 15", rv, 8'h15);

      // R10 hold
      wr(6'h00, 8'h20);
      wr(6'h0B, 8'h82);
      pulse_tick();
      pulse_tick();
      rd(6'h00, rv); chk("R10 frozen in hold", rv, 8'h20);
      wr(6'h0B, 8'h02);
      repeat (4) @(negedge clk);
      rd(6'h00, rv); chk("R10 one pending advance", rv, 8'h21);

      // R11 daylight bit has no effect
      wr(6'h0B, 8'h03);
      wr(6'h00, 8'h59);
      wr(6'h02, 8'h59);
      wr(6'h04, 8'h01);
      pulse_tick();
      rd(6'h04, rv); chk("R11 hour plain step", rv, 8'h02);
      rd(6'h00, rv); chk("R11 sec wrap", rv, 8'h00);
      rd(6'h0B, rv); chk("R11 ctl stored", rv, 8'h03);
      wr(6'h0B, 8'h02);

      // R3 reference path, pulse ignored
      wr(6'h00, 8'h30);
      pulse_sel = 1'b0;
      pulse_tick();
      pulse_tick();
      rd(6'h00, rv); chk("R3 pulse ignored", rv, 8'h30);
      for (int e = 0; e < TB_DIV - 1; e++) ref_edge();
      rd(6'h00, rv); chk("R3 before divide", rv, 8'h30);
      ref_edge();
      rd(6'h00, rv); chk("R3 after divide", rv, 8'h31);
      for (int e = 0; e < TB_DIV; e++) ref_edge();
      rd(6'h00, rv); chk("R3 second period", rv, 8'h32);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule